// File: doc/BRIEF.md
# Debug Scan-Chain Register Access Port

This block sits behind a JTAG TAP controller and lets an external debugger read and write the register file of an on-chip peripheral. It has two test-data paths. The first is a small chain-number register, reached through a chain-select instruction. The second is a frame register, reached through an access instruction. The frame register is only live when the chain number equals the access chain, which is chain 0. The TAP state machine is outside the block. It supplies one-cycle capture, shift and update strobes and the two decoded instruction flags.

Each access frame carries a data word, a register address and a direction flag. On update, a write frame writes the data word to the peripheral straight away. A read frame only records the address. The contents of that address are loaded into the data field at the next capture, so every scan returns the data addressed by the scan before it. Some registers have side effects on read, such as a buffer whose read pointer advances. To stream such a register, the host repeats its address on each scan and puts a harmless address (0) in the last one. The block raises a read strobe once per capture, so the peripheral advances exactly once for each word that the host receives.

Top module: `scan_access_top`

## Requirements
- R1: After reset, `chainSel` is 0, `regAddr` is 0, and `regWrEn` and `regRdStrobe` are low.
- R2: With `irSelChain` set, capture loads the current chain number. The register shifts 5 bits in LSB first from `tdi`, and `tdo` presents the captured bits LSB first. Update loads the shifted value into `chainSel`, which changes at no other time except reset.
- R3: The access frame is 40 bits wide and is shifted LSB first. Bits 31:0 hold the data, bits 38:32 hold the 7-bit register address, and bit 39 holds the direction flag.
- R4: When the flag is 1, the update cycle drives `regWrEn` high for exactly that cycle. In that cycle `regAddr` carries the frame address and `regWrData` carries the frame data.
- R5: When the flag is 0, update performs no write. From the next cycle on, `regAddr` holds the frame address, and it keeps that value until another update or reset.
- R6: On capture, the data field loads `regRdData` for the address latched by the last read update, and the address and flag fields load zeros. The bits then appear on `tdo` LSB first.
- R7: `regRdStrobe` is high for exactly the capture cycle of each access scan, and it is never high during shift or update.
- R8: If the access instruction is active while `chainSel` is not 0, the block makes no write and raises no strobe, `regAddr` does not change, and `tdo` stays 0.
- R9: A `tapReset` cycle clears `chainSel` to 0 and sets the latched read address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tapReset | input | 1 | TAP in test-logic-reset; synchronous clear |
| irSelChain | input | 1 | Decoded chain-select instruction |
| irAccess | input | 1 | Decoded register-access instruction |
| captureDr | input | 1 | Capture-DR strobe |
| shiftDr | input | 1 | Shift-DR strobe |
| updateDr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| chainSel | output | 5 | Current chain number |
| regAddr | output | 7 | Register file address |
| regWrData | output | 32 | Register file write data |
| regWrEn | output | 1 | Register file write enable |
| regRdData | input | 32 | Register file read data for `regAddr` |
| regRdStrobe | output | 1 | One pulse per captured read, for read side effects |

## Verification
The assertions rely on the TAP providing a legal sequence of inputs. At most one of capture, shift and update is high in any cycle, and each capture and each update lasts a single cycle. The two instruction flags are never set together, and neither flag changes in the middle of a scan. The bench drives every scan through a single task that holds one instruction steady for the whole scan, so it cannot create overlapping strobes or multi-cycle strobes. The bench's register-file model answers combinationally for any address. It also advances a pointer register at address 4 on each read strobe, and that is how the bench exposes any duplicated or missing side effect.

// File: rtl/scan_access_pkg.sv
package scan_access_pkg;
  // strobes from the control to the frame datapath
  typedef struct packed {
    logic cap;
    logic shift;
    logic upd;
  } accCtl_t;
endpackage

// File: rtl/scan_access_ctrl.sv
module scan_access_ctrl
  import scan_access_pkg::*;
#(
  parameter int CHAIN_W = 5,
  parameter int ACCESS_CHAIN = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tapReset,
  input  logic               irSelChain,
  input  logic               irAccess,
  input  logic               captureDr,
  input  logic               shiftDr,
  input  logic               updateDr,
  input  logic               tdi,
  output accCtl_t            ctl,
  output logic               accOn,
  output logic               selTdo,
  output logic [CHAIN_W-1:0] chainSel
);
  localparam logic [CHAIN_W-1:0] AccChain = CHAIN_W'(ACCESS_CHAIN);

  logic [CHAIN_W-1:0] chainNum;
  logic [CHAIN_W-1:0] selSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainNum <= '0;
      selSr    <= '0;
    end else if (tapReset) begin
      chainNum <= '0;
      selSr    <= '0;
    end else if (irSelChain) begin
      if (captureDr)      selSr    <= chainNum;
      else if (shiftDr)   selSr    <= {tdi, selSr[CHAIN_W-1:1]};
      else if (updateDr)  chainNum <= selSr;
    end
  end

  always_comb begin
    accOn     = irAccess && !irSelChain && (chainNum == AccChain);
    ctl.cap   = accOn && captureDr;
    ctl.shift = accOn && shiftDr;
    ctl.upd   = accOn && updateDr;
    selTdo    = irSelChain && selSr[0];
  end

  assign chainSel = chainNum;
endmodule

// File: rtl/scan_access_dp.sv
module scan_access_dp
  import scan_access_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tapReset,
  input  accCtl_t           ctl,
  input  logic              tdi,
  input  logic [DATA_W-1:0] regRdData,
  output logic              accTdo,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdStrobe
);
  localparam int FrameW  = DATA_W + ADDR_W + 1;
  localparam int AddrLo  = DATA_W;
  localparam int AddrHi  = DATA_W + ADDR_W - 1;
  localparam int FlagBit = FrameW - 1;

  logic [FrameW-1:0] frameSr;
  logic [ADDR_W-1:0] rdAddr;
  logic              isWrite;

  assign isWrite = frameSr[FlagBit];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSr <= '0;
      rdAddr  <= '0;
    end else if (tapReset) begin
      frameSr <= '0;
      rdAddr  <= '0;
    end else begin
      if (ctl.cap)        frameSr <= {{(ADDR_W + 1){1'b0}}, regRdData};
      else if (ctl.shift) frameSr <= {tdi, frameSr[FrameW-1:1]};
      if (ctl.upd && !isWrite) rdAddr <= frameSr[AddrHi:AddrLo];
    end
  end

  always_comb begin
    regWrEn     = ctl.upd && isWrite;
    regAddr     = regWrEn ? frameSr[AddrHi:AddrLo] : rdAddr;
    regWrData   = frameSr[DATA_W-1:0];
    regRdStrobe = ctl.cap;
    accTdo      = frameSr[0];
  end
endmodule

// File: rtl/scan_access_top.sv
module scan_access_top
  import scan_access_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  parameter int CHAIN_W = 5,
  parameter int ACCESS_CHAIN = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tapReset,
  input  logic               irSelChain,
  input  logic               irAccess,
  input  logic               captureDr,
  input  logic               shiftDr,
  input  logic               updateDr,
  input  logic               tdi,
  output logic               tdo,
  output logic [CHAIN_W-1:0] chainSel,
  output logic [ADDR_W-1:0]  regAddr,
  output logic [DATA_W-1:0]  regWrData,
  output logic               regWrEn,
  input  logic [DATA_W-1:0]  regRdData,
  output logic               regRdStrobe
);
  accCtl_t ctl;
  logic    accOn;
  logic    selTdo;
  logic    accTdo;

  scan_access_ctrl #(.CHAIN_W(CHAIN_W), .ACCESS_CHAIN(ACCESS_CHAIN)) uCtrl (
    .clk(clk), .rstN(rstN), .tapReset(tapReset),
    .irSelChain(irSelChain), .irAccess(irAccess),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .tdi(tdi), .ctl(ctl), .accOn(accOn), .selTdo(selTdo), .chainSel(chainSel)
  );

  scan_access_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .tapReset(tapReset), .ctl(ctl), .tdi(tdi),
    .regRdData(regRdData), .accTdo(accTdo), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn), .regRdStrobe(regRdStrobe)
  );

  assign tdo = selTdo | (accOn & accTdo);
endmodule

// File: rtl/scan_access_chk.sv
module scan_access_chk #(
  parameter int ADDR_W = 7,
  parameter int CHAIN_W = 5,
  parameter int ACCESS_CHAIN = 0
) (
  input logic               clk,
  input logic               rstN,
  input logic               tapReset,
  input logic               irSelChain,
  input logic               irAccess,
  input logic               captureDr,
  input logic               updateDr,
  input logic               tdo,
  input logic [CHAIN_W-1:0] chainSel,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic               regRdStrobe
);
  localparam logic [CHAIN_W-1:0] AccChain = CHAIN_W'(ACCESS_CHAIN);

  AST_WRITE_IN_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (updateDr && irAccess && chainSel == AccChain)); // R4

  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R4

  AST_STROBE_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    regRdStrobe |-> (captureDr && irAccess && chainSel == AccChain)); // R7

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    regRdStrobe |=> !regRdStrobe); // R7

  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!updateDr && !tapReset) |=> (updateDr || $stable(regAddr))); // R5

  AST_CHAIN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!(updateDr && irSelChain) && !tapReset) |=> $stable(chainSel)); // R2

  AST_TAP_RESET: assert property (@(posedge clk) disable iff (!rstN)
    tapReset |=> (chainSel == '0 && (regWrEn || regAddr == '0))); // R9

  AST_OFF_CHAIN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (chainSel != AccChain && !irSelChain) |-> (!regWrEn && !regRdStrobe && !tdo)); // R8
endmodule

bind scan_access_top scan_access_chk #(
  .ADDR_W(ADDR_W), .CHAIN_W(CHAIN_W), .ACCESS_CHAIN(ACCESS_CHAIN)
) uChk (
  .clk(clk), .rstN(rstN), .tapReset(tapReset), .irSelChain(irSelChain),
  .irAccess(irAccess), .captureDr(captureDr), .updateDr(updateDr), .tdo(tdo),
  .chainSel(chainSel), .regAddr(regAddr), .regWrEn(regWrEn),
  .regRdStrobe(regRdStrobe)
);

// File: tb/scan_access_top_test.sv
module scan_access_top_test;
  localparam int ClkPeriod = 10;
  localparam int FifoAddr = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tapReset = 1'b0;
  logic        irSelChain = 1'b0;
  logic        irAccess = 1'b0;
  logic        captureDr = 1'b0;
  logic        shiftDr = 1'b0;
  logic        updateDr = 1'b0;
  logic        tdi = 1'b0;
  logic        tdo;
  logic [4:0]  chainSel;
  logic [6:0]  regAddr;
  logic [31:0] regWrData;
  logic        regWrEn;
  logic [31:0] regRdData;
  logic        regRdStrobe;

  int checks = 0;
  int errors = 0;
  int strobeCnt = 0;

  // peripheral model: plain registers plus a pointer register at FifoAddr
  logic [31:0] mem [128];
  logic [31:0] fifoPtr = 0;
  // bench expectations
  logic [31:0] expMem [128];
  logic [31:0] expPtr = 0;
  logic [6:0]  expRdAddr = 0;

  always #(ClkPeriod / 2) clk = ~clk;

  scan_access_top uut (
    .clk(clk), .rstN(rstN), .tapReset(tapReset), .irSelChain(irSelChain),
    .irAccess(irAccess), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .tdi(tdi), .tdo(tdo), .chainSel(chainSel),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdData(regRdData), .regRdStrobe(regRdStrobe)
  );

  function automatic logic [31:0] initVal(int a);
    return 32'h0101_0101 * a;
  endfunction
  function automatic logic [31:0] wrVal(int a);
    return 32'hC0DE_0000 ^ (32'h0001_0203 * a);
  endfunction

  assign regRdData = (regAddr == 7'(FifoAddr)) ? (32'hF1F0_0000 + fifoPtr) : mem[regAddr];

  always @(posedge clk) begin
    if (regRdStrobe) strobeCnt <= strobeCnt + 1;
    if (regRdStrobe && regAddr == 7'(FifoAddr)) fifoPtr <= fifoPtr + 1;
    if (regWrEn && regAddr != 7'(FifoAddr)) mem[regAddr] <= regWrData;
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // chain-number scan: returns bits seen on tdo
  task automatic chainScan(input logic [4:0] val, output logic [4:0] got);
    irSelChain = 1'b1; irAccess = 1'b0;
    @(negedge clk); captureDr = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); captureDr = 1'b0; shiftDr = 1'b1; tdi = val[i];
      #1 got[i] = tdo;
    end
    @(negedge clk); shiftDr = 1'b0; updateDr = 1'b1;
    @(negedge clk); updateDr = 1'b0; irSelChain = 1'b0;
  endtask

  // access scan: returns captured frame, observed write and strobe delta
  task automatic accScan(input logic [39:0] frame, output logic [39:0] got,
                         output logic wrSeen, output logic [6:0] wrAddr,
                         output logic [31:0] wrData, output int stDelta);
    int st0;
    irAccess = 1'b1; irSelChain = 1'b0;
    st0 = strobeCnt;
    @(negedge clk); captureDr = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); captureDr = 1'b0; shiftDr = 1'b1; tdi = frame[i];
      #1 got[i] = tdo;
    end
    @(negedge clk); shiftDr = 1'b0; updateDr = 1'b1;
    #1 wrSeen = regWrEn; wrAddr = regAddr; wrData = regWrData;
    @(negedge clk); updateDr = 1'b0;
    #1 stDelta = strobeCnt - st0;
  endtask

  function automatic logic [31:0] expRead();
    if (expRdAddr == 7'(FifoAddr)) begin
      expPtr = expPtr + 1;
      return 32'hF1F0_0000 + expPtr - 1;
    end
    return expMem[expRdAddr];
  endfunction

  task automatic readScan(input logic [6:0] a);
    logic [39:0] got; logic ws; logic [6:0] wa; logic [31:0] wd; int sd;
    logic [31:0] exp;
    exp = expRead();
    accScan({1'b0, a, 32'h0}, got, ws, wa, wd, sd);
    check(got[31:0] == exp, "R6 pipelined read data", 64'(got[31:0]), 64'(exp));
    check(got[39:32] == 8'h0, "R3 captured addr/flag zero", 64'(got[39:32]), 64'h0);
    check(!ws, "R5 read makes no write", 64'(ws), 64'h0);
    check(sd == 1, "R7 one strobe per scan", 64'(sd), 64'h1);
    check(regAddr == a, "R5 read address latched", 64'(regAddr), 64'(a));
    expRdAddr = a;
  endtask

  task automatic writeScan(input logic [6:0] a, input logic [31:0] d);
    logic [39:0] got; logic ws; logic [6:0] wa; logic [31:0] wd; int sd;
    logic [31:0] exp;
    exp = expRead();
    accScan({1'b1, a, d}, got, ws, wa, wd, sd);
    check(ws && wa == a && wd == d, "R4 write strobe/addr/data",
          {24'(ws), 8'(wa), wd}, {24'h1, 8'(a), d});
    check(got[31:0] == exp, "R6 capture during write scan", 64'(got[31:0]), 64'(exp));
    check(regAddr == expRdAddr, "R4 read address kept after write", 64'(regAddr), 64'(expRdAddr));
    if (a != 7'(FifoAddr)) expMem[a] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 64'h0, 64'h1);
    summary();
  end

  initial begin
    logic [4:0]  cg;
    logic [39:0] got; logic ws; logic [6:0] wa; logic [31:0] wd; int sd;
    for (int a = 0; a < 128; a++) begin
      mem[a] = initVal(a);
      expMem[a] = initVal(a);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(chainSel == 0 && regAddr == 0 && !regWrEn && !regRdStrobe, "R1 reset outputs",
          {chainSel, regAddr, regWrEn, regRdStrobe}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 chain select and readback
    chainScan(5'h13, cg);
    check(cg == 5'h00, "R2 captured chain number", 64'(cg), 64'h0);
    check(chainSel == 5'h13, "R2 chain updated", 64'(chainSel), 64'h13);

    // R8 access on a non-zero chain is ignored
    accScan({1'b1, 7'd9, 32'hDEAD_BEEF}, got, ws, wa, wd, sd);
    check(got == 40'h0, "R8 tdo quiet off chain", 64'(got), 64'h0);
    check(!ws && sd == 0, "R8 no write or strobe off chain", {32'(ws), 32'(sd)}, 64'h0);
    check(regAddr == 0, "R8 address unchanged off chain", 64'(regAddr), 64'h0);

    chainScan(5'h00, cg);
    check(cg == 5'h13, "R2 chain readback", 64'(cg), 64'h13);
    check(chainSel == 5'h00, "R2 access chain selected", 64'(chainSel), 64'h0);

    // R8 cont.: location 9 still holds its initial value
    readScan(7'd9);
    readScan(7'd0);

    // R4 write sweep over every address
    for (int a = 0; a < 128; a++) writeScan(7'(a), wrVal(a));

    // R5/R6 pipelined read sweep, last scan returns to address 0
    for (int a = 0; a < 128; a++) readScan(7'(a));
    readScan(7'd0);

    // R7 streaming the pointer register: repeat address, end on 0
    for (int k = 0; k < 4; k++) readScan(7'(FifoAddr));
    readScan(7'd0);
    check(fifoPtr == expPtr, "R7 pointer advanced once per word", 64'(fifoPtr), 64'(expPtr));

    // R9 TAP reset
    readScan(7'd11);
    chainScan(5'h05, cg);
    @(negedge clk); tapReset = 1'b1;
    @(negedge clk); tapReset = 1'b0;
    #1 check(chainSel == 0 && regAddr == 0, "R9 tap reset clears chain and address",
             {chainSel, regAddr}, 64'h0);
    expRdAddr = 7'd0;
    readScan(7'd2);

    summary();
  end
endmodule